// File: doc/BRIEF.md
# SPI Command Segment Sequencer

This block is the engine behind a single-lane SPI master. A command word describes one segment: how many bytes to exchange, and whether chip select stays low when the segment ends. Once a command is accepted, the block drives the selected chip select low and waits out a lead delay. It then shifts each byte out on MOSI while it captures MISO, and finally waits out a trail delay and an idle delay before it reports ready again. Each chip select has its own configuration word, which sets the SCLK divider, the chip-select lead, trail and idle times, and the clock polarity and phase. A chip-select index register picks which configuration word is read and written. The same index also picks the chip select that a new command uses.

Bytes to send come from a TX FIFO through a valid/ready stream. A byte moves only in a cycle where both `tx_valid` and `tx_ready` are high. Received bytes leave through a second valid/ready stream. Once `rx_valid` is raised, it and `rx_data` hold until `rx_ready` takes the byte. The block never drops or overwrites data. A new byte starts only when a TX byte is on offer and the previous received byte has been taken. Until then the block pauses with SCLK frozen and flags which side is holding it up.

The command, configuration, index, enable and reset inputs are plain one-cycle strobes and levels. The error flags are sticky and are cleared only by a reset.

Top module: `spi_seg_seq`

## Requirements
- R1: One 32-bit configuration word is stored per chip select. `cfg_wr` writes the word at the current index, and `cfg_rdata` shows it. Field positions:
  - bits 15:0 divider
  - bits 19:16 idle
  - bits 23:20 trail
  - bits 27:24 lead
  - bit 29 full-cycle (stored only)
  - bit 30 CPHA
  - bit 31 CPOL
- R2: Writing an index value at or above `NUM_CS` leaves the index unchanged and sets `err_csid`.
- R3: The command word carries the byte count minus one in bits 7:0, the hold flag in bit 9, the speed in bits 11:10 and the direction in bits 13:12. A command whose speed is not 0, or whose direction is not 2'b11 (full duplex), sets `err_cmd_inval` and is not executed.
- R4: While `ctrl_en` is low, a command is dropped with no error and no bus activity.
- R5: An accepted command drops `ready` (and raises `active`) on the next cycle until the segment ends. A command that arrives while `ready` is low sets `err_cmd_busy` and is not executed.
- R6: A segment exchanges count+1 bytes, most significant bit first. One SCLK half-period lasts divider+1 clocks, and SCLK rests at CPOL. With CPHA=0, data is sampled on the leading edge; with CPHA=1, on the trailing edge. Each received byte appears on the RX stream.
- R7: At least lead+1 half-periods pass between a chip-select fall and the first SCLK edge. Between segments without hold, chip select stays high for at least idle+1 half-periods.
- R8: When the hold flag is set, chip select stays low after the segment and `ready` returns. The next command continues on the same chip select with no new fall.
- R9: If no TX byte is offered at a byte boundary, `tx_stall` rises and SCLK freezes until a byte arrives. No bits are lost.
- R10: If the previous RX byte is still untaken at a byte boundary, `rx_stall` rises and shifting pauses. `rx_data` holds steady while `rx_valid` waits for `rx_ready`.
- R11: A `sw_rst` pulse ends any segment:
  - all chip selects go high on the next cycle
  - `ready` returns
  - the configuration words, the index and the error flags clear
  - `fifo_flush` pulses for one cycle so that both FIFOs empty
- R12: After reset, all chip selects are high, `ready` is high and `active` is low. At most one chip select is ever low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; commands are dropped while low |
| sw_rst | input | 1 | Software reset strobe |
| fifo_flush | output | 1 | One-cycle pulse asking both FIFOs to empty |
| csid_wr | input | 1 | Index write strobe |
| csid_wdata | input | 32 | New chip-select index |
| csid | output | CSW | Current chip-select index |
| cfg_wr | input | 1 | Configuration write strobe for the current index |
| cfg_wdata | input | 32 | Configuration word to store |
| cfg_rdata | output | 32 | Configuration word at the current index |
| cmd_valid | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word |
| ready | output | 1 | Able to accept a command |
| active | output | 1 | Segment in progress |
| tx_stall | output | 1 | Paused waiting for a TX byte |
| rx_stall | output | 1 | Paused waiting for RX space |
| err_cmd_busy | output | 1 | Sticky: command arrived while busy |
| err_cmd_inval | output | 1 | Sticky: unsupported speed or direction |
| err_csid | output | 1 | Sticky: index out of range |
| tx_valid | input | 1 | TX byte available |
| tx_data | input | 8 | TX byte |
| tx_ready | output | 1 | Block takes the TX byte this cycle |
| rx_valid | output | 1 | RX byte available |
| rx_data | output | 8 | RX byte |
| rx_ready | input | 1 | Sink takes the RX byte |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csn | output | NUM_CS | Active-low chip selects |

## Verification
The hardest states to reach are the two pauses at a byte boundary, and telling them apart. For a TX stall, the bench offers fewer TX bytes than the command asks for. For an RX stall, it holds `rx_ready` low so that the first received byte stays parked. In both cases it watches SCLK stay frozen for many half-periods before releasing the stream, and then checks that every bit still arrives in order.

With MISO looped back to MOSI, a wire monitor rebuilds the bytes at the sampling edge that the selected phase calls for. The received stream therefore checks both the bit order and the edge choice. The hold and busy cases are reached by issuing a second command right after, or during, a segment.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef struct packed {
    logic        cpol;
    logic        cpha;
    logic        fullcyc;
    logic        rsvd;
    logic [3:0]  lead;
    logic [3:0]  trail;
    logic [3:0]  idle;
    logic [15:0] clkdiv;
  } cfg_t;

  typedef struct packed {
    logic [17:0] pad_hi;
    logic [1:0]  dir;
    logic [1:0]  speed;
    logic        hold;
    logic        pad_lo;
    logic [7:0]  len;
  } cmd_t;

  localparam logic [1:0] DIR_DUPLEX = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_LOAD, S_SHIFT, S_TRAIL, S_GAP, S_HOLD
  } seq_st_e;

endpackage

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CSW    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           csid_wr,
  input  logic [31:0]    csid_wdata,
  input  logic           cfg_wr,
  input  logic [31:0]    cfg_wdata,
  output logic [CSW-1:0] csid_q,
  output logic [31:0]    cfg_rdata,
  output cfg_t           sel_cfg,
  output logic           err_csid
);

  logic [31:0] cfg_r [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cfg_r[i] <= '0;
      else if (clr)                            cfg_r[i] <= '0;
      else if (cfg_wr && csid_q == CSW'(i))    cfg_r[i] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csid_q   <= '0;
      err_csid <= 1'b0;
    end else if (clr) begin
      csid_q   <= '0;
      err_csid <= 1'b0;
    end else if (csid_wr) begin
      if (csid_wdata < 32'(NUM_CS)) csid_q   <= csid_wdata[CSW-1:0];
      else                          err_csid <= 1'b1;
    end
  end

  assign cfg_rdata = cfg_r[csid_q];
  assign sel_cfg   = cfg_t'(cfg_r[csid_q]);

  // R2
  csid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(csid_q) < 32'(NUM_CS));

  // R2
  csid_bad_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csid_wr && !clr && csid_wdata >= 32'(NUM_CS)) |=> ($stable(csid_q) && err_csid));

endmodule

// File: rtl/spi_cmd_check.sv
module spi_cmd_check
  import spi_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        cmd_valid,
  input  logic [31:0] cmd_word,
  input  logic        ctrl_en,
  input  logic        ready,
  output logic        accept,
  output logic [7:0]  len,
  output logic        hold,
  output logic        err_busy,
  output logic        err_inval
);

  cmd_t cmd;
  logic legal;
  logic live;
  logic unused_cmd;

  assign cmd        = cmd_t'(cmd_word);
  assign legal      = (cmd.speed == 2'b00) && (cmd.dir == DIR_DUPLEX);
  assign live       = cmd_valid && ctrl_en && !clr;
  assign accept     = live && ready && legal;
  assign len        = cmd.len;
  assign hold       = cmd.hold;
  assign unused_cmd = ^{cmd.pad_hi, cmd.pad_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_busy  <= 1'b0;
      err_inval <= 1'b0;
    end else if (clr) begin
      err_busy  <= 1'b0;
      err_inval <= 1'b0;
    end else begin
      if (live && !ready)          err_busy  <= 1'b1;
      if (live && ready && !legal) err_inval <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CSW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic [7:0]        start_len,
  input  logic              start_hold,
  input  logic [CSW-1:0]    start_cs,
  input  cfg_t              start_cfg,
  output logic              ready,
  output logic              tx_stall,
  output logic              rx_stall,
  input  logic              tx_valid,
  input  logic [7:0]        tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  input  logic              rx_ready,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csn
);

  seq_st_e        st;
  cfg_t           cfg_q;
  logic [CSW-1:0] cs_q;
  logic [7:0]     left_q;
  logic           hold_q;
  logic [15:0]    hp_cnt;
  logic [3:0]     half_q;
  logic [7:0]     txb_q, rxb_q;
  logic           sclk_q, mosi_q, cs_act;
  logic           tick, timed;
  logic           unused_cfg;

  assign timed      = (st == S_LEAD) || (st == S_SHIFT) || (st == S_TRAIL) || (st == S_GAP);
  assign tick       = timed && (hp_cnt == cfg_q.clkdiv);
  assign ready      = (st == S_IDLE) || (st == S_HOLD);
  assign tx_ready   = (st == S_LOAD) && !rx_valid;
  assign tx_stall   = (st == S_LOAD) && !rx_valid && !tx_valid;
  assign rx_stall   = (st == S_LOAD) && rx_valid;
  assign sclk       = sclk_q;
  assign mosi       = mosi_q;
  assign unused_cfg = ^{cfg_q.fullcyc, cfg_q.rsvd};

  for (genvar i = 0; i < NUM_CS; i++) begin : g_csn
    assign csn[i] = !(cs_act && cs_q == CSW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hp_cnt <= '0;
    else if (clr)    hp_cnt <= '0;
    else if (!timed) hp_cnt <= '0;
    else if (tick)   hp_cnt <= '0;
    else             hp_cnt <= hp_cnt + 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cfg_q <= '0; cs_q <= '0; left_q <= '0; hold_q <= 1'b0;
      half_q <= '0; txb_q <= '0; rxb_q <= '0; sclk_q <= 1'b0; mosi_q <= 1'b0;
      cs_act <= 1'b0; rx_valid <= 1'b0; rx_data <= '0;
    end else if (clr) begin
      st <= S_IDLE; cfg_q <= '0; cs_q <= '0; left_q <= '0; hold_q <= 1'b0;
      half_q <= '0; txb_q <= '0; rxb_q <= '0; sclk_q <= 1'b0; mosi_q <= 1'b0;
      cs_act <= 1'b0; rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          cfg_q  <= start_cfg;
          cs_q   <= start_cs;
          sclk_q <= start_cfg.cpol;
          cs_act <= 1'b1;
          left_q <= start_len;
          hold_q <= start_hold;
          half_q <= '0;
          st     <= S_LEAD;
        end
        S_HOLD: if (start) begin
          left_q <= start_len;
          hold_q <= start_hold;
          st     <= S_LOAD;
        end
        S_LEAD: if (tick) begin
          if (half_q == cfg_q.lead) begin
            half_q <= '0;
            st     <= S_LOAD;
          end else half_q <= half_q + 4'd1;
        end
        S_LOAD: if (tx_ready && tx_valid) begin
          txb_q  <= tx_data;
          if (!cfg_q.cpha) mosi_q <= tx_data[7];
          half_q <= '0;
          st     <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          sclk_q <= ~sclk_q;
          if (half_q[0] == cfg_q.cpha)  rxb_q  <= {rxb_q[6:0], miso};
          else if (cfg_q.cpha)          mosi_q <= txb_q[3'd7 - half_q[3:1]];
          else if (half_q != 4'd15)     mosi_q <= txb_q[3'd6 - half_q[3:1]];
          if (half_q == 4'd15) begin
            rx_valid <= 1'b1;
            rx_data  <= cfg_q.cpha ? {rxb_q[6:0], miso} : rxb_q;
            half_q   <= '0;
            if (left_q == 8'd0) st <= hold_q ? S_HOLD : S_TRAIL;
            else begin
              left_q <= left_q - 8'd1;
              st     <= S_LOAD;
            end
          end else half_q <= half_q + 4'd1;
        end
        S_TRAIL: if (tick) begin
          if (half_q == cfg_q.trail) begin
            half_q <= '0;
            cs_act <= 1'b0;
            st     <= S_GAP;
          end else half_q <= half_q + 4'd1;
        end
        S_GAP: if (tick) begin
          if (half_q == cfg_q.idle) begin
            half_q <= '0;
            st     <= S_IDLE;
          end else half_q <= half_q + 4'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R12
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~csn) <= 1);

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R9
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (tx_stall || rx_stall) |=> $stable(sclk));

  // R5
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    start |=> !ready);

endmodule

// File: rtl/spi_seg_seq.sv
module spi_seg_seq
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en,
  input  logic              sw_rst,
  output logic              fifo_flush,
  input  logic              csid_wr,
  input  logic [31:0]       csid_wdata,
  output logic [CSW-1:0]    csid,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              cmd_valid,
  input  logic [31:0]       cmd_word,
  output logic              ready,
  output logic              active,
  output logic              tx_stall,
  output logic              rx_stall,
  output logic              err_cmd_busy,
  output logic              err_cmd_inval,
  output logic              err_csid,
  input  logic              tx_valid,
  input  logic [7:0]        tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  input  logic              rx_ready,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csn
);

  cfg_t       sel_cfg;
  logic       accept;
  logic [7:0] cmd_len;
  logic       cmd_hold;
  logic       flush_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= sw_rst;
  end
  assign fifo_flush = flush_q;
  assign active     = !ready;

  spi_cfg_bank #(.NUM_CS(NUM_CS), .CSW(CSW)) u_bank (
    .clk, .rst_n, .clr(sw_rst),
    .csid_wr, .csid_wdata, .cfg_wr, .cfg_wdata,
    .csid_q(csid), .cfg_rdata, .sel_cfg, .err_csid
  );

  spi_cmd_check u_check (
    .clk, .rst_n, .clr(sw_rst),
    .cmd_valid, .cmd_word, .ctrl_en, .ready,
    .accept, .len(cmd_len), .hold(cmd_hold),
    .err_busy(err_cmd_busy), .err_inval(err_cmd_inval)
  );

  spi_shift_engine #(.NUM_CS(NUM_CS), .CSW(CSW)) u_eng (
    .clk, .rst_n, .clr(sw_rst),
    .start(accept), .start_len(cmd_len), .start_hold(cmd_hold),
    .start_cs(csid), .start_cfg(sel_cfg),
    .ready, .tx_stall, .rx_stall,
    .tx_valid, .tx_data, .tx_ready,
    .rx_valid, .rx_data, .rx_ready,
    .sclk, .mosi, .miso, .csn
  );

  // R11
  sw_rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (&csn && ready && fifo_flush));

endmodule

// File: tb/spi_seg_seq_bench.sv
module spi_seg_seq_bench;
  localparam int NCS = 4;
  localparam logic [31:0] CFG0 = 32'h0213_0001; // cpol0 cpha0 lead2 trail1 idle3 div1
  localparam logic [31:0] CFG1 = 32'hC001_0000; // cpol1 cpha1 lead0 trail0 idle1 div0

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ctrl_en, sw_rst, fifo_flush, csid_wr, cfg_wr, cmd_valid;
  logic [31:0] csid_wdata, cfg_wdata, cfg_rdata, cmd_word;
  logic [1:0] csid;
  logic ready, active, tx_stall, rx_stall, err_cmd_busy, err_cmd_inval, err_csid;
  logic tx_valid, tx_ready, rx_valid, rx_ready, sclk, mosi, miso;
  logic [7:0] tx_data, rx_data;
  logic [NCS-1:0] csn;

  spi_seg_seq #(.NUM_CS(NCS)) u_spi_seg_seq (.*);

  assign miso = mosi;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // TX source and RX sink models
  logic [7:0] txq [64];
  int tx_wr = 0, tx_rd = 0;
  logic tx_gate = 1'b1, rx_gate = 1'b1;
  logic [7:0] rxq [64];
  int rx_n = 0;
  assign tx_valid = tx_gate && (tx_rd != tx_wr);
  assign tx_data  = txq[tx_rd[5:0]];
  assign rx_ready = rx_gate;
  always @(posedge clk) begin
    if (tx_valid && tx_ready) tx_rd <= tx_rd + 1;
    if (rx_valid && rx_ready) begin rxq[rx_n[5:0]] <= rx_data; rx_n <= rx_n + 1; end
  end

  // Wire monitor
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  logic mon_cpol = 0, mon_cpha = 0, sclk_prev = 0, act_prev = 0;
  logic [7:0] wsh, wq [64];
  int wn = 0, wbits = 0, edge_cnt = 0, fall_cnt = 0, rise_cnt = 0;
  int t_e1 = 0, t_e2 = 0, t_fall = 0, t_rise = 0, last_gap = 0;
  always @(negedge clk) begin
    logic act_now;
    act_now = (csn != '1);
    if (act_now && act_prev && sclk != sclk_prev) begin
      edge_cnt++;
      if (edge_cnt == 1) t_e1 = cyc;
      if (edge_cnt == 2) t_e2 = cyc;
      if ((sclk != mon_cpol) == (mon_cpha == 1'b0)) begin
        wsh = {wsh[6:0], mosi};
        wbits++;
        if (wbits == 8) begin wq[wn[5:0]] = wsh; wn++; wbits = 0; end
      end
    end
    if (act_now && !act_prev) begin
      if (rise_cnt > 0) last_gap = cyc - t_rise;
      t_fall = cyc; fall_cnt++;
    end
    if (!act_now && act_prev) begin t_rise = cyc; rise_cnt++; end
    sclk_prev = sclk;
    act_prev  = act_now;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcmd(input int len, input bit hold,
                                        input int speed, input int dir);
    return 32'(len & 255) | (32'(hold) << 9) | (32'(speed & 3) << 10) | (32'(dir & 3) << 12);
  endfunction

  task automatic clear_mon();
    @(negedge clk);
    edge_cnt = 0; wn = 0; wbits = 0; fall_cnt = 0; rise_cnt = 0;
    tx_wr = 0; tx_rd = 0; rx_n = 0; last_gap = 0;
  endtask

  task automatic push(input logic [7:0] b);
    txq[tx_wr[5:0]] = b;
    tx_wr++;
  endtask

  task automatic set_csid(input logic [31:0] v);
    @(negedge clk); csid_wr = 1; csid_wdata = v;
    @(negedge clk); csid_wr = 0;
  endtask

  task automatic set_cfg(input logic [31:0] v);
    @(negedge clk); cfg_wr = 1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk); cmd_valid = 1; cmd_word = w;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 5000 && !ready; i++) @(negedge clk);
  endtask

  task automatic do_sw_rst();
    @(negedge clk); sw_rst = 1;
    @(negedge clk); sw_rst = 0;
  endtask

  task automatic setup();
    set_csid(1); set_cfg(CFG1);
    set_csid(0); set_cfg(CFG0);
  endtask

  task automatic check_bytes(input string req, input int n);
    chk(wn == n, {req, " wire count"}, wn, n);
    chk(rx_n == n, {req, " rx count"}, rx_n, n);
    for (int i = 0; i < n; i++) begin
      chk(wq[i] == txq[i], {req, " wire byte"}, wq[i], txq[i]);
      chk(rxq[i] == txq[i], {req, " rx byte"}, rxq[i], txq[i]);
    end
  endtask

  task automatic t_reset_state();
    chk(ready == 1 && active == 0, "R12 ready after reset", {ready, active}, 2'b10);
    chk(csn == '1, "R12 csn after reset", csn, 4'hF);
    chk({err_cmd_busy, err_cmd_inval, err_csid} == 0, "R12 errors after reset", 0, 0);
    chk(cfg_rdata == 0, "R12 cfg after reset", cfg_rdata, 0);
  endtask

  task automatic t_cfg_bank();
    set_csid(0); set_cfg(32'h1234_5678);
    set_csid(1); set_cfg(32'h8765_4321);
    @(negedge clk);
    chk(cfg_rdata == 32'h8765_4321, "R1 cfg cs1", cfg_rdata, 32'h8765_4321);
    set_csid(0); @(negedge clk);
    chk(cfg_rdata == 32'h1234_5678, "R1 cfg cs0", cfg_rdata, 32'h1234_5678);
  endtask

  task automatic t_csid_bad();
    set_csid(2); set_csid(NCS); @(negedge clk);
    chk(csid == 2, "R2 csid kept", csid, 2);
    chk(err_csid == 1, "R2 csid error", err_csid, 1);
  endtask

  task automatic t_mode0();
    clear_mon(); mon_cpol = 0; mon_cpha = 0;
    push(8'hA5); push(8'h3C); push(8'h81);
    issue(mkcmd(2, 0, 0, 3));
    chk(ready == 0 && active == 1, "R5 busy after accept", {ready, active}, 2'b01);
    wait_ready();
    check_bytes("R6 mode0", 3);
    chk(edge_cnt == 48, "R6 edge count", edge_cnt, 48);
    chk(t_e2 - t_e1 == 2, "R6 half period", t_e2 - t_e1, 2);
    chk(t_e1 - t_fall >= 6, "R7 lead time", t_e1 - t_fall, 6);
    chk(sclk == 0 && csn == '1, "R6 idle levels", {sclk, csn}, 5'h0F);
  endtask

  task automatic t_mode3();
    clear_mon(); mon_cpol = 1; mon_cpha = 1;
    set_csid(1);
    push(8'h5A); push(8'hF0);
    issue(mkcmd(1, 0, 0, 3));
    @(negedge clk);
    chk(csn == 4'b1101, "R12 only cs1 low", csn, 4'b1101);
    wait_ready();
    check_bytes("R6 mode3", 2);
    chk(t_e2 - t_e1 == 1, "R6 half period div0", t_e2 - t_e1, 1);
    chk(sclk == 1, "R6 idle cpol1", sclk, 1);
    set_csid(0); mon_cpol = 0; mon_cpha = 0;
  endtask

  task automatic t_hold();
    clear_mon();
    push(8'h11); push(8'h22);
    issue(mkcmd(0, 1, 0, 3));
    wait_ready();
    chk(csn[0] == 0, "R8 cs held", csn[0], 0);
    issue(mkcmd(0, 0, 0, 3));
    wait_ready();
    chk(fall_cnt == 1 && rise_cnt == 1, "R8 single frame", fall_cnt * 16 + rise_cnt, 17);
    check_bytes("R8 held data", 2);
  endtask

  task automatic t_gap();
    clear_mon();
    push(8'h66); push(8'h99);
    issue(mkcmd(0, 0, 0, 3));
    wait_ready();
    issue(mkcmd(0, 0, 0, 3));
    wait_ready();
    chk(fall_cnt == 2, "R7 two frames", fall_cnt, 2);
    chk(last_gap >= 8, "R7 idle gap", last_gap, 8);
  endtask

  task automatic t_tx_stall();
    logic s0;
    clear_mon();
    push(8'hC3);
    issue(mkcmd(1, 0, 0, 3));
    for (int i = 0; i < 500 && !tx_stall; i++) @(negedge clk);
    chk(tx_stall == 1 && rx_stall == 0, "R9 tx stall flag", {tx_stall, rx_stall}, 2'b10);
    s0 = sclk;
    repeat (20) @(negedge clk);
    chk(sclk == s0 && edge_cnt == 16, "R9 sclk frozen", edge_cnt, 16);
    push(8'h7E);
    wait_ready();
    check_bytes("R9 data intact", 2);
  endtask

  task automatic t_rx_stall();
    clear_mon();
    rx_gate = 0;
    push(8'hB4); push(8'h4B);
    issue(mkcmd(1, 0, 0, 3));
    for (int i = 0; i < 500 && !rx_stall; i++) @(negedge clk);
    chk(rx_stall == 1 && rx_valid == 1, "R10 rx stall flag", {rx_stall, rx_valid}, 2'b11);
    chk(rx_data == 8'hB4, "R10 parked byte", rx_data, 8'hB4);
    repeat (20) @(negedge clk);
    chk(edge_cnt == 16 && rx_data == 8'hB4, "R10 paused", edge_cnt, 16);
    rx_gate = 1;
    wait_ready();
    check_bytes("R10 data intact", 2);
  endtask

  task automatic t_busy();
    clear_mon();
    push(8'h01); push(8'h02); push(8'h03); push(8'h04); push(8'h05);
    issue(mkcmd(3, 0, 0, 3));
    repeat (10) @(negedge clk);
    issue(mkcmd(0, 0, 0, 3));
    chk(err_cmd_busy == 1, "R5 busy error", err_cmd_busy, 1);
    wait_ready();
    repeat (60) @(negedge clk);
    chk(wn == 4 && fall_cnt == 1, "R5 second not run", wn, 4);
    do_sw_rst(); setup();
  endtask

  task automatic t_inval();
    clear_mon();
    issue(mkcmd(0, 0, 1, 3));
    repeat (20) @(negedge clk);
    chk(err_cmd_inval == 1 && fall_cnt == 0, "R3 speed rejected", {err_cmd_inval, fall_cnt[0]}, 2'b10);
    do_sw_rst(); setup();
    issue(mkcmd(0, 0, 0, 1));
    repeat (20) @(negedge clk);
    chk(err_cmd_inval == 1 && fall_cnt == 0 && ready == 1, "R3 direction rejected",
        {err_cmd_inval, fall_cnt[0]}, 2'b10);
    do_sw_rst(); setup();
  endtask

  task automatic t_disabled();
    clear_mon();
    ctrl_en = 0;
    push(8'hEE);
    issue(mkcmd(0, 0, 0, 3));
    repeat (30) @(negedge clk);
    chk(fall_cnt == 0 && tx_rd == 0, "R4 no activity", fall_cnt, 0);
    chk({err_cmd_busy, err_cmd_inval} == 0, "R4 no error", {err_cmd_busy, err_cmd_inval}, 0);
    ctrl_en = 1;
  endtask

  task automatic t_sw_rst();
    clear_mon();
    push(8'h10); push(8'h20); push(8'h30); push(8'h40);
    issue(mkcmd(3, 0, 0, 3));
    repeat (40) @(negedge clk);
    chk(csn[0] == 0, "R11 mid segment", csn[0], 0);
    sw_rst = 1;
    @(negedge clk); sw_rst = 0;
    chk(csn == '1 && ready == 1, "R11 bus released", {csn, ready}, 5'h1F);
    chk(fifo_flush == 1, "R11 flush pulse", fifo_flush, 1);
    chk(cfg_rdata == 0 && csid == 0, "R11 regs cleared", cfg_rdata, 0);
    @(negedge clk);
    chk(fifo_flush == 0, "R11 flush one cycle", fifo_flush, 0);
    tx_rd = tx_wr;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ctrl_en = 1; sw_rst = 0; csid_wr = 0; cfg_wr = 0; cmd_valid = 0;
    csid_wdata = 0; cfg_wdata = 0; cmd_word = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_cfg_bank();
    t_csid_bad();
    do_sw_rst(); setup();
    t_mode0();
    t_mode3();
    t_hold();
    t_gap();
    t_tx_stall();
    t_rx_stall();
    t_busy();
    t_inval();
    t_disabled();
    t_sw_rst();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule